// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register storage for a 32-bit processor with seven operating modes. Each mode sees sixteen architectural registers, addressed by a 4-bit index. Some indices resolve to a copy that belongs only to the current mode; the rest resolve to storage that several modes share. The block has two combinational read ports and one write port. It also holds one current status word and a saved status word for each exception mode.

The mode comes in on a 5-bit input. A bank-override input makes the general registers use the unprivileged mapping, whatever the mode. A low-register qualifier limits access to indices 0 to 7. A companion permit input lifts that limit for the few operations that may reach the high registers. Instruction decode, exception sequencing and program-counter arithmetic are outside this block.

Top module: `banked_regfile`

## Requirements
- R1: Modes are encoded as User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. System and every unlisted encoding behave exactly as User.
- R2: Indices 0 to 7 resolve to one physical set that every mode shares.
- R3: In FIQ mode, indices 8 to 12 resolve to registers private to FIQ. All other modes share one common copy of indices 8 to 12.
- R4: Indices 13 and 14 resolve to a separate pair in each of six banks: User/System, FIQ, IRQ, Supervisor, Abort and Undefined.
- R5: Index 15 resolves to one physical register that every mode sees.
- R6: When lo_only_i is 1 and hi_ok_i is 0, a read of an index of 8 or above returns zero, and a write to such an index is ignored.
- R7: A general register write takes effect at the rising clock edge. A read in the same cycle that resolves to the register being written returns wr_data_i, on either port.
- R8: There is one current status word, shared by all modes. cpsr_we_i loads it at the clock edge, and cpsr_q_o shows the stored value.
- R9: Each of the five exception modes has its own saved status word. spsr_q_o shows the word for the current mode, and spsr_we_i loads it. In User/System mode spsr_q_o is zero and spsr_we_i has no effect.
- R10: While user_bank_i is 1, general register reads and writes use the User/System mapping. The saved status access still follows mode_i.
- R11: A synchronous reset clears every general and saved status register and loads the current status word with 0x00000013.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Current operating mode |
| user_bank_i | input | 1 | Force User/System mapping for general registers |
| lo_only_i | input | 1 | Restrict access to indices 0 to 7 |
| hi_ok_i | input | 1 | Permit high indices under the restriction |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_q_o | output | 32 | Current status value |
| spsr_we_i | input | 1 | Saved status write enable |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_q_o | output | 32 | Saved status of the current mode |

## Verification
A wrong bank mapping does not show up when the write happens. It shows up at a later read of the same index from another mode: that read returns a value written in that other mode where the shared or private value was expected. A lost or misdirected write shows up the first time the affected register is read again. The bench therefore switches modes often and reads both ports every cycle. A broken bypass shows up in the same cycle as the write, and a broken saved status word shows up on the next cycle spent in that mode.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter logic [4:0] RST_MODE = 5'b10011
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode_i,
  input  logic          user_bank_i,
  input  logic          lo_only_i,
  input  logic          hi_ok_i,
  input  logic [3:0]    rd_a_idx_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [3:0]    rd_b_idx_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cpsr_we_i,
  input  logic [DW-1:0] cpsr_wdata_i,
  output logic [DW-1:0] cpsr_q_o,
  input  logic          spsr_we_i,
  input  logic [DW-1:0] spsr_wdata_i,
  output logic [DW-1:0] spsr_q_o
);
  localparam int NPHYS  = 31;
  localparam int PW     = $clog2(NPHYS);
  localparam int NEXC   = 5;
  localparam int PC_LOC = NPHYS - 1;

  logic [DW-1:0] regs [NPHYS];
  logic [DW-1:0] spsr [NEXC];
  logic [DW-1:0] cpsr;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: return 3'd1;
      5'b10010: return 3'd2;
      5'b10011: return 3'd3;
      5'b10111: return 3'd4;
      5'b11011: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [PW-1:0] phys(input logic [3:0] idx, input logic [2:0] b);
    int p;
    if (idx < 4'd8)        p = int'(idx);
    else if (idx == 4'd15) p = PC_LOC;
    else if (b == 3'd1)    p = int'(idx) + 5;
    else if (idx <= 4'd12) p = int'(idx);
    else if (b == 3'd0)    p = int'(idx) + 7;
    else                   p = int'(idx) + 5 + 2 * int'(b);
    return PW'(p);
  endfunction

  logic [2:0]    gp_bank, st_bank;
  logic          wr_ok;
  logic [PW-1:0] wr_p;

  assign st_bank = bank_of(mode_i);
  assign gp_bank = user_bank_i ? 3'd0 : st_bank;
  assign wr_ok   = wr_en_i && (!lo_only_i || hi_ok_i || !wr_idx_i[3]);
  assign wr_p    = phys(wr_idx_i, gp_bank);

  logic [3:0]    rd_idx [2];
  logic [DW-1:0] rd_dat [2];
  assign rd_idx[0]   = rd_a_idx_i;
  assign rd_idx[1]   = rd_b_idx_i;
  assign rd_a_data_o = rd_dat[0];
  assign rd_b_data_o = rd_dat[1];

  for (genvar g = 0; g < 2; g++) begin : g_rd
    logic [PW-1:0] p;
    logic          ok;
    assign p  = phys(rd_idx[g], gp_bank);
    assign ok = !lo_only_i || hi_ok_i || !rd_idx[g][3];
    assign rd_dat[g] = !ok ? '0 : (wr_ok && wr_p == p) ? wr_data_i : regs[p];
  end

  assign cpsr_q_o = cpsr;
  assign spsr_q_o = (st_bank == 3'd0) ? '0 : spsr[st_bank - 3'd1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
      for (int i = 0; i < NEXC; i++) spsr[i] <= '0;
      cpsr <= DW'(RST_MODE);
    end else begin
      if (wr_ok) regs[wr_p] <= wr_data_i;
      if (cpsr_we_i) cpsr <= cpsr_wdata_i;
      if (spsr_we_i && st_bank != 3'd0) spsr[st_bank - 3'd1] <= spsr_wdata_i;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    mode_i,
  input logic          lo_only_i,
  input logic          hi_ok_i,
  input logic [3:0]    rd_a_idx_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic [3:0]    rd_b_idx_i,
  input logic [DW-1:0] rd_b_data_o,
  input logic          wr_en_i,
  input logic [3:0]    wr_idx_i,
  input logic [DW-1:0] wr_data_i,
  input logic          cpsr_we_i,
  input logic [DW-1:0] cpsr_q_o,
  input logic [DW-1:0] spsr_q_o
);
  logic hi_open, wr_go;
  assign hi_open = !lo_only_i || hi_ok_i;
  assign wr_go   = wr_en_i && (hi_open || !wr_idx_i[3]);

  p_lo_restrict_r6: assert property (@(posedge clk) disable iff (rst)
    (!hi_open && rd_a_idx_i[3]) |-> rd_a_data_o == '0);

  p_bypass_a_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rd_a_idx_i == wr_idx_i && (hi_open || !rd_a_idx_i[3])) |-> rd_a_data_o == wr_data_i);

  p_bypass_b_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rd_b_idx_i == wr_idx_i && (hi_open || !rd_b_idx_i[3])) |-> rd_b_data_o == wr_data_i);

  p_pc_shared_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_go && wr_idx_i == 4'd15) && rd_a_idx_i == 4'd15 && hi_open
     && !(wr_go && wr_idx_i == 4'd15)) |-> rd_a_data_o == $past(wr_data_i));

  p_cpsr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cpsr_we_i)) |-> $stable(cpsr_q_o));

  p_spsr_user_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !(mode_i inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011}) |-> spsr_q_o == '0);
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .mode_i(mode_i), .lo_only_i(lo_only_i), .hi_ok_i(hi_ok_i),
  .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
  .rd_b_idx_i(rd_b_idx_i), .rd_b_data_o(rd_b_data_o),
  .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
  .cpsr_we_i(cpsr_we_i), .cpsr_q_o(cpsr_q_o), .spsr_q_o(spsr_q_o)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic clk = 0, rst = 1;
  logic [4:0] mode_i = 5'b10000;
  logic user_bank_i = 0, lo_only_i = 0, hi_ok_i = 0;
  logic [3:0] rd_a_idx_i = 0, rd_b_idx_i = 0, wr_idx_i = 0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = 0;
  logic wr_en_i = 0, cpsr_we_i = 0, spsr_we_i = 0;
  logic [31:0] cpsr_wdata_i = 0, spsr_wdata_i = 0, cpsr_q_o, spsr_q_o;

  always #10 clk = ~clk;

  banked_regfile dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] m_lo [8];
  logic [31:0] m_mid [5];
  logic [31:0] m_fq [7];
  logic [31:0] m_pair [6][2];
  logic [31:0] m_pc, m_cpsr;
  logic [31:0] m_sv [6];

  localparam logic [4:0] MODES [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10111, 5'b11011, 5'b11111, 5'b00101};

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit allowed(input logic [3:0] idx);
    return !lo_only_i || hi_ok_i || idx < 8;
  endfunction

  function automatic logic [31:0] stored(input logic [3:0] idx, input int b);
    if (idx < 8) return m_lo[idx];
    if (idx == 15) return m_pc;
    if (b == 1) return m_fq[idx - 8];
    if (idx < 13) return m_mid[idx - 8];
    return m_pair[b][idx - 13];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] idx);
    int b = user_bank_i ? 0 : bk(mode_i);
    if (!allowed(idx)) return 32'h0;
    if (wr_en_i && allowed(wr_idx_i) && wr_idx_i == idx) return wr_data_i;
    return stored(idx, b);
  endfunction

  function automatic string tag_of(input logic [3:0] idx);
    if (!allowed(idx)) return "R6";
    if (wr_en_i && wr_idx_i == idx) return "R7";
    if (user_bank_i && bk(mode_i) != 0) return "R10";
    if (bk(mode_i) == 0 && mode_i != 5'b10000) return "R1";
    if (idx < 8) return "R2";
    if (idx < 13) return "R3";
    if (idx < 15) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_update();
    int b = user_bank_i ? 0 : bk(mode_i);
    int s = bk(mode_i);
    if (rst) begin
      foreach (m_lo[i]) m_lo[i] = 0;
      foreach (m_mid[i]) m_mid[i] = 0;
      foreach (m_fq[i]) m_fq[i] = 0;
      foreach (m_pair[i, j]) m_pair[i][j] = 0;
      foreach (m_sv[i]) m_sv[i] = 0;
      m_pc = 0;
      m_cpsr = 32'h13;
      return;
    end
    if (wr_en_i && allowed(wr_idx_i)) begin
      if (wr_idx_i < 8) m_lo[wr_idx_i] = wr_data_i;
      else if (wr_idx_i == 15) m_pc = wr_data_i;
      else if (b == 1) m_fq[wr_idx_i - 8] = wr_data_i;
      else if (wr_idx_i < 13) m_mid[wr_idx_i - 8] = wr_data_i;
      else m_pair[b][wr_idx_i - 13] = wr_data_i;
    end
    if (cpsr_we_i) m_cpsr = cpsr_wdata_i;
    if (spsr_we_i && s != 0) m_sv[s] = spsr_wdata_i;
  endtask

  task automatic cyc(input string force_tag = "");
    #2;
    if (!rst) begin
      chk(force_tag != "" ? force_tag : tag_of(rd_a_idx_i), rd_a_data_o, exp_rd(rd_a_idx_i));
      chk(force_tag != "" ? force_tag : tag_of(rd_b_idx_i), rd_b_data_o, exp_rd(rd_b_idx_i));
      chk("R8", cpsr_q_o, m_cpsr);
      chk("R9", spsr_q_o, bk(mode_i) == 0 ? 32'h0 : m_sv[bk(mode_i)]);
    end
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en_i = 0; cpsr_we_i = 0; spsr_we_i = 0;
    user_bank_i = 0; lo_only_i = 0; hi_ok_i = 0;
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] idx, input logic [31:0] d);
    idle(); mode_i = m; wr_en_i = 1; wr_idx_i = idx; wr_data_i = d;
    rd_a_idx_i = idx; rd_b_idx_i = idx;
    cyc("R7");
    wr_en_i = 0;
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] idx, input string tag);
    idle(); mode_i = m; rd_a_idx_i = idx; rd_b_idx_i = idx;
    cyc(tag);
  endtask

  task automatic sweep_reset();
    for (int m = 0; m < 7; m++)
      for (int i = 0; i < 16; i += 2) begin
        idle(); mode_i = MODES[m]; rd_a_idx_i = 4'(i); rd_b_idx_i = 4'(i + 1);
        cyc("R11");
      end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; cyc(); cyc();
    rst = 0;
    sweep_reset();

    // R2: shared low register across modes
    wr(5'b10001, 4'd3, 32'hA5A5_0003);
    rd(5'b10011, 4'd3, "R2");
    // R3: FIQ private vs common high registers
    wr(5'b10000, 4'd9, 32'h0000_1009);
    wr(5'b10001, 4'd9, 32'hF1F1_0009);
    rd(5'b10010, 4'd9, "R3");
    rd(5'b10001, 4'd9, "R3");
    // R4: banked pairs
    for (int m = 0; m < 6; m++) wr(MODES[m], 4'd13, 32'h5000_0000 + 32'(m));
    for (int m = 0; m < 8; m++) rd(MODES[m], 4'd13, "R4");
    // R5: single program counter
    wr(5'b11011, 4'd15, 32'h0000_8000);
    rd(5'b10001, 4'd15, "R5");
    // R1: System and unlisted encodings alias User
    wr(5'b11111, 4'd14, 32'h1111_1414);
    rd(5'b10000, 4'd14, "R1");
    rd(5'b01010, 4'd14, "R1");
    // R10: override in exception mode
    idle(); mode_i = 5'b10010; user_bank_i = 1; wr_en_i = 1; wr_idx_i = 4'd13;
    wr_data_i = 32'hC0DE_0013; rd_a_idx_i = 4'd14; rd_b_idx_i = 4'd13; cyc("R10");
    rd(5'b10000, 4'd13, "R10");
    rd(5'b10010, 4'd13, "R10");
    // R6: restricted write to high index ignored, then visible state
    idle(); mode_i = 5'b10000; lo_only_i = 1; wr_en_i = 1; wr_idx_i = 4'd10;
    wr_data_i = 32'hDEAD_BEEF; rd_a_idx_i = 4'd10; rd_b_idx_i = 4'd2; cyc("R6");
    rd(5'b10000, 4'd10, "R6");
    idle(); lo_only_i = 1; hi_ok_i = 1; wr_en_i = 1; wr_idx_i = 4'd10;
    wr_data_i = 32'h0000_0A0A; rd_a_idx_i = 4'd10; cyc("R6");
    // R9: saved status in user ignored, per-mode otherwise
    idle(); mode_i = 5'b10000; spsr_we_i = 1; spsr_wdata_i = 32'hFFFF_FFFF; cyc("R9");
    idle(); mode_i = 5'b10111; spsr_we_i = 1; spsr_wdata_i = 32'h0000_00D7; cyc("R9");
    rd(5'b10011, 4'd0, "R9");
    rd(5'b10111, 4'd0, "R9");
    // R8: current status load
    idle(); cpsr_we_i = 1; cpsr_wdata_i = 32'h6000_001F; cyc("R8");
    rd(5'b10001, 4'd1, "R8");

    for (int n = 0; n < 3000; n++) begin
      idle();
      mode_i = ($urandom % 10 == 0) ? 5'($urandom) : MODES[$urandom % 7];
      user_bank_i = ($urandom % 8 == 0);
      lo_only_i = ($urandom % 8 == 0);
      hi_ok_i = ($urandom % 2 == 0);
      wr_en_i = ($urandom % 2 == 0);
      wr_idx_i = 4'($urandom);
      wr_data_i = $urandom;
      rd_a_idx_i = 4'($urandom);
      rd_b_idx_i = ($urandom % 4 == 0) ? wr_idx_i : 4'($urandom);
      cpsr_we_i = ($urandom % 8 == 0);
      cpsr_wdata_i = $urandom;
      spsr_we_i = ($urandom % 4 == 0);
      spsr_wdata_i = $urandom;
      if (n == 1500) begin
        idle(); rst = 1; cyc(); rst = 0;
        sweep_reset();
      end else cyc();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule